// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a 16-bit down-counter that raises an interrupt each time it passes through zero. Software programs it through a small synchronous register port with three halfword registers: a control/status word, a modulus, and a read-only view of the live count. The count steps once per prescaled tick. Each tick period is the system clock divided by two, and then divided again by a power of two chosen in the control word.

In reload mode the counter restarts from the modulus after zero, so the interrupt period is fixed. In free-running mode it wraps to 0xFFFF instead, and the modulus only matters when an overwrite load forces the count. The run/stop behaviour is a two-state machine. STOPPED is the reset state. The START transition moves it to COUNTING on the cycle after the enable bit reads 1. The HALT transition returns it to STOPPED on the cycle after enable reads 0. The prescale divider is held at zero while STOPPED.

Top module: `pit_timer`

## Requirements
- R1: After reset, the control word reads 0x0000, the modulus reads 0xFFFF, the count reads 0xFFFF and `irq` is low.
- R2: Offset 0 reads the control word, with the prescale exponent in bits 11:8, overwrite at bit 4, interrupt enable at bit 3, flag at bit 2, reload mode at bit 1 and run enable at bit 0; all other bits read 0. Offset 2 reads the modulus and offset 4 reads the count.
- R3: While running, the count changes once every 2·2^P clocks, where P is the prescale exponent. While STOPPED the count holds.
- R4: With reload mode set, a tick taken at count 0 loads the modulus into the counter and sets the flag.
- R5: With reload mode clear, a tick taken at count 0 loads 0xFFFF and sets the flag.
- R6: Any write to offset 2 clears the flag, unless a zero-crossing sets it in that same cycle.
- R7: A write to offset 2 with overwrite set loads the written value into the counter on the next cycle, in either mode. With overwrite clear, only the stored modulus changes.
- R8: A write to offset 0 restarts the prescale divider. Writing 1 to bit 2 of the control word clears the flag; writing 0 to that bit leaves it unchanged.
- R9: `irq` is high exactly when the flag and the interrupt enable bit are both set.
- R10: A write to offset 4 has no effect. Any other offset reads as 0, ignores writes, and raises `acc_err` during the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_off | input | 4 | Byte offset of the halfword register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_off` (combinational) |
| acc_err | output | 1 | High during an access to an undefined offset |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the zero crossing in both modes. A design that reloads from the wrong source would show 0xFFFF in reload mode, or the modulus in free-running mode. A design that sets the flag a tick late would shift `irq` by a whole prescale period. It also checks that an overwrite load takes effect in free-running mode, and that a plain modulus write leaves the count alone. A design that copied the reload/free-run condition wrongly would either drop the load or move the count. It also sends writes to the count offset and to undefined offsets, and pulses the flag-clear bit. A decoder that aliased offsets would corrupt the modulus or the count, and a flag that cleared on a write of 0 would lose interrupts.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 4;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_MOD   = 4'h2;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 4'h4;

    localparam int BIT_EN   = 0;
    localparam int BIT_RLD  = 1;
    localparam int BIT_FLAG = 2;
    localparam int BIT_IE   = 3;
    localparam int BIT_OVW  = 4;
    localparam int PRE_LSB  = 8;

    typedef enum logic {
        ST_STOPPED  = 1'b0,
        ST_COUNTING = 1'b1
    } run_state_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    localparam int DIV_W = 2 ** PRE_W;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   span;

    // terminal value = 2*2^pre - 1
    always_comb begin
        span = ({{DIV_W{1'b0}}, 1'b1} << ({1'b0, pre} + 1'b1)) - 1'b1;
    end

    assign tick = run && (div_q == span[DIV_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!run || restart || tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             reload_mode,
    input  logic [CNT_W-1:0] modulus,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             run,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt
);
    import pit_pkg::*;

    run_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // transitions: START and HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED:  if (en)  state_d = ST_COUNTING;
            ST_COUNTING: if (!en) state_d = ST_STOPPED;
        endcase
    end

    // outputs
    always_comb begin
        run   = (state_q == ST_COUNTING);
        wrap  = tick && (cnt == '0);
        cnt_d = cnt;
        if (load)
            cnt_d = load_val;
        else if (wrap)
            cnt_d = reload_mode ? modulus : {CNT_W{1'b1}};
        else if (tick)
            cnt_d = cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= {CNT_W{1'b1}};
        else        cnt <= cnt_d;
    end

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));
    // R4
    reload_from_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && reload_mode && !load) |=> cnt == $past(modulus));
    // R5
    freerun_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && !reload_mode && !load) |=> cnt == {CNT_W{1'b1}});
    // R7
    overwrite_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
endmodule

// File: rtl/pit_regs.sv
module pit_regs #(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_off,
    input  logic [15:0]       bus_wdata,
    input  logic              wrap,
    input  logic [CNT_W-1:0]  cnt,
    output logic [PRE_W-1:0]  pre,
    output logic              en,
    output logic              rld,
    output logic              ie,
    output logic              restart,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  modulus,
    output logic [15:0]       bus_rdata,
    output logic              acc_err,
    output logic              irq
);
    import pit_pkg::*;

    logic ovw, flag;
    logic wr_ctrl, wr_mod, off_ok;
    logic [15:0] ctrl_word;
    logic unused_wbits;

    assign unused_wbits = ^{bus_wdata[15:PRE_LSB+PRE_W], bus_wdata[PRE_LSB-1:BIT_OVW+1]};

    assign off_ok  = (bus_off == OFF_CTRL) || (bus_off == OFF_MOD) || (bus_off == OFF_COUNT);
    assign wr_ctrl = bus_sel && bus_wr && (bus_off == OFF_CTRL);
    assign wr_mod  = bus_sel && bus_wr && (bus_off == OFF_MOD);
    assign acc_err = bus_sel && !off_ok;

    assign restart  = wr_ctrl;
    assign load     = wr_mod && ovw;
    assign load_val = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0; en <= 1'b0; rld <= 1'b0; ie <= 1'b0; ovw <= 1'b0;
            modulus <= {CNT_W{1'b1}};
        end else begin
            if (wr_ctrl) begin
                pre <= bus_wdata[PRE_LSB +: PRE_W];
                en  <= bus_wdata[BIT_EN];
                rld <= bus_wdata[BIT_RLD];
                ie  <= bus_wdata[BIT_IE];
                ovw <= bus_wdata[BIT_OVW];
            end
            if (wr_mod)
                modulus <= bus_wdata[CNT_W-1:0];
        end
    end

    // flag: a zero-crossing wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (wrap)
            flag <= 1'b1;
        else if (wr_mod || (wr_ctrl && bus_wdata[BIT_FLAG]))
            flag <= 1'b0;
    end

    assign irq = flag && ie;

    always_comb begin
        ctrl_word = '0;
        ctrl_word[PRE_LSB +: PRE_W] = pre;
        ctrl_word[BIT_OVW]  = ovw;
        ctrl_word[BIT_IE]   = ie;
        ctrl_word[BIT_FLAG] = flag;
        ctrl_word[BIT_RLD]  = rld;
        ctrl_word[BIT_EN]   = en;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_off)
            OFF_CTRL:  bus_rdata = ctrl_word;
            OFF_MOD:   bus_rdata = 16'(modulus);
            OFF_COUNT: bus_rdata = 16'(cnt);
            default:   bus_rdata = '0;
        endcase
    end

    // R6
    mod_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mod && !wrap) |=> !flag);
    // R8
    w1c_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[BIT_FLAG] && !wrap) |=> !flag);
    // R9
    irq_follows_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !wr_ctrl) |=> (irq == ie));
    // R10
    bad_offset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (bus_rdata == 16'h0000));
endmodule

// File: rtl/pit_timer.sv
module pit_timer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_off,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        acc_err,
    output logic        irq
);
    import pit_pkg::*;

    logic [PRE_W-1:0] pre;
    logic en, rld, ie, restart, load, run, tick, wrap;
    logic [CNT_W-1:0] load_val, modulus, cnt;

    pit_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_off(bus_off), .bus_wdata(bus_wdata),
        .wrap(wrap), .cnt(cnt),
        .pre(pre), .en(en), .rld(rld), .ie(ie), .restart(restart),
        .load(load), .load_val(load_val), .modulus(modulus),
        .bus_rdata(bus_rdata), .acc_err(acc_err), .irq(irq)
    );

    pit_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .pre(pre), .tick(tick)
    );

    pit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .reload_mode(rld), .modulus(modulus),
        .load(load), .load_val(load_val),
        .run(run), .wrap(wrap), .cnt(cnt)
    );
endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_off = 4'h4;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        acc_err;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    int m_pre, m_mod, m_cnt, m_div;
    bit m_en, m_rld, m_ie, m_ovw, m_flag, m_run;

    pit_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_off(bus_off), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .acc_err(acc_err), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic int model_read(input int off);
        int w;
        case (off)
            0: begin
                w = (m_pre << 8) | (int'(m_ovw) << 4) | (int'(m_ie) << 3)
                  | (int'(m_flag) << 2) | (int'(m_rld) << 1) | int'(m_en);
                return w;
            end
            2: return m_mod;
            4: return m_cnt;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit wr_ctrl, wr_mod, tick, wrapev, n_flag;
        int n_cnt, n_div;
        if (!rst_n) begin
            m_pre = 0; m_en = 0; m_rld = 0; m_ie = 0; m_ovw = 0; m_flag = 0;
            m_mod = 16'hFFFF; m_cnt = 16'hFFFF; m_div = 0; m_run = 0;
        end else begin
            wr_ctrl = bus_sel && bus_wr && bus_off == 4'h0;
            wr_mod  = bus_sel && bus_wr && bus_off == 4'h2;
            tick    = m_run && (m_div == ((2 << m_pre) - 1));
            wrapev  = tick && (m_cnt == 0);
            if (wr_mod && m_ovw)      n_cnt = int'(bus_wdata);
            else if (wrapev)          n_cnt = m_rld ? m_mod : 16'hFFFF;
            else if (tick)            n_cnt = m_cnt - 1;
            else                      n_cnt = m_cnt;
            n_div = (!m_run || wr_ctrl || tick) ? 0 : m_div + 1;
            n_flag = m_flag;
            if (wr_mod || (wr_ctrl && bus_wdata[2])) n_flag = 0;
            if (wrapev) n_flag = 1;
            m_run = m_en;
            m_cnt = n_cnt; m_div = n_div; m_flag = n_flag;
            if (wr_ctrl) begin
                m_pre = int'(bus_wdata[11:8]);
                m_ovw = bus_wdata[4]; m_ie = bus_wdata[3];
                m_rld = bus_wdata[1]; m_en = bus_wdata[0];
            end
            if (wr_mod) m_mod = int'(bus_wdata);
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        int exp_rd;
        bit exp_err, exp_irq;
        if (rst_n) begin
            exp_rd  = model_read(int'(bus_off));
            exp_err = bus_sel && !(bus_off == 4'h0 || bus_off == 4'h2 || bus_off == 4'h4);
            exp_irq = m_flag && m_ie;
            checks++;
            if (int'(bus_rdata) != exp_rd) begin
                errors++;
                $display("FAIL %s: rdata at offset %0d got %h expected %h", cur_req, bus_off, bus_rdata, exp_rd[15:0]);
            end
            checks++;
            if (irq != exp_irq) begin
                errors++;
                $display("FAIL R9 (%s): irq got %0b expected %0b", cur_req, irq, exp_irq);
            end
            checks++;
            if (acc_err != exp_err) begin
                errors++;
                $display("FAIL R10 (%s): acc_err got %0b expected %0b", cur_req, acc_err, exp_err);
            end
        end
    end

    task automatic bus_write(input logic [3:0] o, input logic [15:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_off = o; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_off = 4'h4;
    endtask

    task automatic peek(input logic [3:0] o);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_off = o;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_off = 4'h4;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog (%s): run did not finish, got %0d cycles expected fewer", cur_req, cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values
        cur_req = "R1";
        idle(2); peek(4'h0); peek(4'h2);
        // R2 field layout, only defined bits kept
        cur_req = "R2";
        bus_write(4'h0, 16'hF3F8); peek(4'h0); peek(4'h2);
        // R7 overwrite load in free-run mode, then plain modulus write
        cur_req = "R7";
        bus_write(4'h0, 16'h0010);
        bus_write(4'h2, 16'd10); idle(2);
        bus_write(4'h0, 16'h0000);
        bus_write(4'h2, 16'd20); idle(2); peek(4'h2);
        // R4 reload mode, prescale 0
        cur_req = "R4";
        bus_write(4'h0, 16'h001B);
        bus_write(4'h2, 16'd3); idle(30);
        // R8 write-one clears flag, write-zero keeps it
        cur_req = "R8";
        bus_write(4'h0, 16'h001B); peek(4'h0);
        bus_write(4'h0, 16'h001F); idle(6);
        // R6 modulus write clears flag
        cur_req = "R6";
        idle(6); bus_write(4'h2, 16'd5); peek(4'h0); idle(15);
        // R9 interrupt enable masks irq
        cur_req = "R9";
        bus_write(4'h0, 16'h0013); idle(25);
        bus_write(4'h0, 16'h001B); idle(4);
        // R5 free-run wrap to 0xFFFF, prescale 1
        cur_req = "R5";
        bus_write(4'h0, 16'h0115);
        bus_write(4'h2, 16'd2); idle(30);
        // R3 prescale 2 rate, then stop holds count
        cur_req = "R3";
        bus_write(4'h0, 16'h0205); idle(60);
        bus_write(4'h0, 16'h0204); idle(30);
        // R10 count offset and undefined offsets
        cur_req = "R10";
        bus_write(4'h4, 16'h1234); peek(4'h4);
        peek(4'h6); bus_write(4'h6, 16'h0001);
        peek(4'h8); bus_write(4'hE, 16'hFFFF);
        bus_write(4'h1, 16'h0000);
        peek(4'h0); peek(4'h2); idle(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule